// File: doc/BRIEF.md
# Compressed Program Counter Tracer

This block records the program counter of every opcode the core executes, illegal opcodes included, into a trace memory made of 20-bit rows. Each row has a 2-bit info field in its top bits and an 18-bit payload. Most opcodes run in the same 64-byte region as the one before them. For these the block keeps only the low six PC bits as an offset and packs two offsets into one row. When execution moves to a different 64-byte region, the block writes a row that holds the full 18-bit PC.

Tracing runs while the arm input is high. The first opcode after arming always produces a full-PC row, so any reader can rebuild the PC stream from the start of the trace. When the arm input drops, the block flushes any offset or full PC that is still held back. Rows leave through a simple write port: an enable, an address and data. A row counter gives the next write address. It wraps over a 64-row memory and raises a sticky overflow flag when it wraps. Execution order is preserved: a pending offset is always written before the full-PC row that follows it.

Top module: `pcTraceCompressor`

## Requirements
- R1: Opcode strobes are accepted only while `armIn` is high. A strobe seen while `armIn` is low writes no row and leaves `rowCount` unchanged.
- R2: A row is 20 bits: info in bits 19:18, payload in bits 17:0. Info 01 means one offset, 10 means two offsets and 11 means a full PC. A written row never carries info 00, which marks an empty row.
- R3: Within one 64-byte region an opcode is recorded as the offset PC[5:0]. In a one-offset row the offset sits in bits 5:0 and bits 17:6 are zero. In a two-offset row the earlier offset sits in bits 5:0, the later one in bits 11:6, and bits 17:12 are zero.
- R4: An opcode whose PC[17:6] differs from the region of the last recorded opcode produces a full row, info 11 with the PC in bits 17:0.
- R5: The first accepted opcode after `armIn` rises always produces a full-PC row, whatever its region.
- R6: A second offset in the same region completes the row. The two-offset row is written at the clock edge that samples that second strobe.
- R7: If an offset is pending when a full-PC row is needed, the pending offset is written first as a one-offset row, and the full-PC row follows on the next edge. An opcode strobed on that next edge is still recorded, either as a new pending offset or as the next full-PC row.
- R8: When `armIn` goes low, any pending offset or held-back full PC is written at the next edge. No further row is written while `armIn` stays low.
- R9: `rowWrAddr` carries the counter value before the write, and `rowCount` advances by one on each row write. It wraps from 63 to 0.
- R10: `overflowFlag` is set by the write to address 63 and stays set until `armIn` rises again. A rise of `armIn` clears both `rowCount` and `overflowFlag` at its sampling edge.
- R11: A row appears on the write port at the same edge that samples the opcode strobe that causes it, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Tracing enable level; a rise starts a new trace |
| opValid | input | 1 | Executed-opcode strobe |
| opPc | input | 18 | PC of the executed opcode |
| rowWrEn | output | 1 | Row write enable |
| rowWrAddr | output | 6 | Row write address |
| rowWrData | output | 20 | Row data: info in 19:18, payload in 17:0 |
| rowCount | output | 6 | Next row address (rows written, modulo 64) |
| overflowFlag | output | 1 | Sticky flag: the trace memory has wrapped |

## Verification
The tracer is driven with opcode runs that stay in one region, spaced and back to back, so that one-offset and two-offset rows and the flush on disarm can be told apart. Region changes are placed in three positions: after a pending offset, right after a held-back full PC, and with nothing pending. These show whether the pending row is written first and whether a full PC that follows another full PC is lost or merged. A run of 66 region-changing opcodes exposes the address wrap and the sticky overflow, and re-arming shows the clear. Strobes while disarmed check that nothing is recorded.

// File: rtl/pcTracePkg.sv
package pcTracePkg;

  typedef enum logic [1:0] {
    INFO_EMPTY = 2'b00,
    INFO_ONE   = 2'b01,
    INFO_TWO   = 2'b10,
    INFO_FULL  = 2'b11
  } rowInfoE;

  typedef struct packed {
    logic wrOne;        // write the pending offset alone
    logic wrTwo;        // write the pending offset plus the incoming one
    logic wrFullNow;    // write the incoming PC as a full row
    logic wrDeferred;   // write the held-back full PC
    logic loadPend;     // hold the incoming offset as pending
    logic loadDeferred; // hold the incoming PC for a full row next edge
    logic saveRegion;   // incoming PC becomes the reference region
    logic clearCount;   // a new trace starts: clear the counter and the flag
  } ctrlStrobeS;

endpackage

// File: rtl/pcTraceCtrl.sv
module pcTraceCtrl
  import pcTracePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       opValid,
  input  logic       regionMatch,
  output ctrlStrobeS strobe
);

  logic armQ;
  logic firstFlag, firstNext;
  logic pendValid, pendNext;
  logic defValid, defNext;
  logic accept, needFull;

  assign accept   = armIn & opValid;
  assign needFull = accept & (firstFlag | ~regionMatch);

  always_comb begin
    strobe     = '0;
    firstNext  = firstFlag;
    pendNext   = pendValid;
    defNext    = defValid;
    strobe.clearCount = armIn & ~armQ;

    if (!armIn) begin
      firstNext = 1'b1;
      if (defValid) begin
        strobe.wrDeferred = 1'b1;
        defNext = 1'b0;
      end else if (pendValid) begin
        strobe.wrOne = 1'b1;
        pendNext = 1'b0;
      end
    end else begin
      if (accept) firstNext = 1'b0;
      if (defValid) begin
        // the write port belongs to the held-back PC on this edge
        strobe.wrDeferred = 1'b1;
        defNext = 1'b0;
        if (needFull) begin
          strobe.loadDeferred = 1'b1;
          strobe.saveRegion   = 1'b1;
          defNext = 1'b1;
        end else if (accept) begin
          strobe.loadPend = 1'b1;
          pendNext = 1'b1;
        end
      end else if (needFull) begin
        strobe.saveRegion = 1'b1;
        if (pendValid) begin
          strobe.wrOne        = 1'b1;
          strobe.loadDeferred = 1'b1;
          pendNext = 1'b0;
          defNext  = 1'b1;
        end else begin
          strobe.wrFullNow = 1'b1;
        end
      end else if (accept) begin
        if (pendValid) begin
          strobe.wrTwo = 1'b1;
          pendNext = 1'b0;
        end else begin
          strobe.loadPend = 1'b1;
          pendNext = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ      <= 1'b0;
      firstFlag <= 1'b1;
      pendValid <= 1'b0;
      defValid  <= 1'b0;
    end else begin
      armQ      <= armIn;
      firstFlag <= firstNext;
      pendValid <= pendNext;
      defValid  <= defNext;
    end
  end

endmodule

// File: rtl/pcTraceDatapath.sv
module pcTraceDatapath
  import pcTracePkg::*;
#(
  parameter int PC_W  = 18,
  parameter int OFF_W = 6,
  localparam int ROW_W = PC_W + 2,
  localparam int REG_W = PC_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  opPc,
  input  ctrlStrobeS       strobe,
  output logic             regionMatch,
  output logic             anyWrite,
  output logic             rowWrEn,
  output logic [ROW_W-1:0] rowWrData
);

  localparam int PAD_ONE = PC_W - OFF_W;
  localparam int PAD_TWO = PC_W - 2 * OFF_W;

  logic [REG_W-1:0] lastRegion;
  logic [OFF_W-1:0] pendOff;
  logic [PC_W-1:0]  defPc;
  logic [ROW_W-1:0] rowNext;
  logic [OFF_W-1:0] inOff;

  assign inOff       = opPc[OFF_W-1:0];
  assign regionMatch = (opPc[PC_W-1:OFF_W] == lastRegion);
  assign anyWrite    = strobe.wrOne | strobe.wrTwo | strobe.wrFullNow | strobe.wrDeferred;

  always_comb begin
    rowNext = '0;
    unique case (1'b1)
      strobe.wrOne:      rowNext = {INFO_ONE, {PAD_ONE{1'b0}}, pendOff};
      strobe.wrTwo:      rowNext = {INFO_TWO, {PAD_TWO{1'b0}}, inOff, pendOff};
      strobe.wrFullNow:  rowNext = {INFO_FULL, opPc};
      strobe.wrDeferred: rowNext = {INFO_FULL, defPc};
      default:           rowNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRegion <= '0;
      pendOff    <= '0;
      defPc      <= '0;
      rowWrEn    <= 1'b0;
      rowWrData  <= '0;
    end else begin
      if (strobe.saveRegion)   lastRegion <= opPc[PC_W-1:OFF_W];
      if (strobe.loadPend)     pendOff    <= inOff;
      if (strobe.loadDeferred) defPc      <= opPc;
      rowWrEn   <= anyWrite;
      rowWrData <= anyWrite ? rowNext : '0;
    end
  end

endmodule

// File: rtl/pcTraceRowCounter.sv
module pcTraceRowCounter #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyWrite,
  input  logic              clearCount,
  output logic [ADDR_W-1:0] rowWrAddr,
  output logic [ADDR_W-1:0] rowCount,
  output logic              overflowFlag
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] base;
  logic              flagBase;

  assign base     = clearCount ? '0 : rowCount;
  assign flagBase = clearCount ? 1'b0 : overflowFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowWrAddr    <= '0;
      rowCount     <= '0;
      overflowFlag <= 1'b0;
    end else begin
      rowCount     <= base;
      overflowFlag <= flagBase;
      if (anyWrite) begin
        rowWrAddr <= base;
        rowCount  <= (base == LAST) ? '0 : base + 1'b1;
        if (base == LAST) overflowFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcTraceCompressor.sv
module pcTraceCompressor
  import pcTracePkg::*;
#(
  parameter int PC_W  = 18,
  parameter int OFF_W = 6,
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armIn,
  input  logic              opValid,
  input  logic [PC_W-1:0]   opPc,
  output logic              rowWrEn,
  output logic [ADDR_W-1:0] rowWrAddr,
  output logic [PC_W+1:0]   rowWrData,
  output logic [ADDR_W-1:0] rowCount,
  output logic              overflowFlag
);

  ctrlStrobeS strobe;
  logic       regionMatch;
  logic       anyWrite;

  pcTraceCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .armIn      (armIn),
    .opValid    (opValid),
    .regionMatch(regionMatch),
    .strobe     (strobe)
  );

  pcTraceDatapath #(.PC_W(PC_W), .OFF_W(OFF_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .opPc       (opPc),
    .strobe     (strobe),
    .regionMatch(regionMatch),
    .anyWrite   (anyWrite),
    .rowWrEn    (rowWrEn),
    .rowWrData  (rowWrData)
  );

  pcTraceRowCounter #(.DEPTH(DEPTH)) uCount (
    .clk         (clk),
    .rstN        (rstN),
    .anyWrite    (anyWrite),
    .clearCount  (strobe.clearCount),
    .rowWrAddr   (rowWrAddr),
    .rowCount    (rowCount),
    .overflowFlag(overflowFlag)
  );

endmodule

// File: rtl/pcTraceChecker.sv
module pcTraceChecker #(
  parameter int PC_W   = 18,
  parameter int OFF_W  = 6,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              armIn,
  input logic              opValid,
  input logic              rowWrEn,
  input logic [ADDR_W-1:0] rowWrAddr,
  input logic [PC_W+1:0]   rowWrData,
  input logic [ADDR_W-1:0] rowCount,
  input logic              overflowFlag
);

  logic [1:0] info;
  assign info = rowWrData[PC_W+1:PC_W];

  // R2
  info_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowWrEn |-> info != 2'b00);

  // R3
  one_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowWrEn && info == 2'b01) |-> rowWrData[PC_W-1:OFF_W] == '0);

  // R3
  two_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowWrEn && info == 2'b10) |-> rowWrData[PC_W-1:2*OFF_W] == '0);

  // R5
  first_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armIn && !$past(armIn) && opValid) |=> (rowWrEn && info == 2'b11));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armIn && !$past(armIn)) |=> !rowWrEn);

  // R9
  addr_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowWrEn |-> rowCount == ADDR_W'(rowWrAddr + 1'b1));

  // R10
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !(armIn && !$past(armIn))) |=> overflowFlag);

endmodule

bind pcTraceCompressor pcTraceChecker #(.PC_W(PC_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .armIn       (armIn),
  .opValid     (opValid),
  .rowWrEn     (rowWrEn),
  .rowWrAddr   (rowWrAddr),
  .rowWrData   (rowWrData),
  .rowCount    (rowCount),
  .overflowFlag(overflowFlag)
);

// File: tb/tb_pcTraceCompressor.sv
module tb_pcTraceCompressor;

  localparam int CLK_PERIOD = 10;
  localparam int CAP_N = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armIn = 1'b0;
  logic        opValid = 1'b0;
  logic [17:0] opPc = '0;
  logic        rowWrEn;
  logic [5:0]  rowWrAddr;
  logic [19:0] rowWrData;
  logic [5:0]  rowCount;
  logic        overflowFlag;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int capN = 0;
  int lastIssue = 0;
  logic [19:0] capData [CAP_N];
  logic [5:0]  capAddr [CAP_N];
  int          capCyc  [CAP_N];

  pcTraceCompressor dut (
    .clk(clk), .rstN(rstN), .armIn(armIn), .opValid(opValid), .opPc(opPc),
    .rowWrEn(rowWrEn), .rowWrAddr(rowWrAddr), .rowWrData(rowWrData),
    .rowCount(rowCount), .overflowFlag(overflowFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && rowWrEn && capN < CAP_N) begin
      capData[capN] = rowWrData;
      capAddr[capN] = rowWrAddr;
      capCyc[capN]  = cyc;
      capN = capN + 1;
    end
  end

  function automatic logic [19:0] mkFull(logic [17:0] pc);
    return {2'b11, pc};
  endfunction
  function automatic logic [19:0] mkOne(logic [5:0] a);
    return {2'b01, 12'b0, a};
  endfunction
  function automatic logic [19:0] mkTwo(logic [5:0] a, logic [5:0] b);
    return {2'b10, 6'b0, b, a};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [17:0] pc);
    opValid = 1'b1;
    opPc = pc;
    lastIssue = cyc + 1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic idle(int n);
    opValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic armDown();
    opValid = 1'b0;
    armIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    check("R9 reset rowWrEn", 32'(rowWrEn), 0);
    check("R9 reset rowCount", 32'(rowCount), 0);
    check("R10 reset overflowFlag", 32'(overflowFlag), 0);
  endtask

  task automatic tPackInRegion();
    int s = capN;
    int firstCyc, pairCyc;
    armIn = 1'b1;
    issue(18'h01000); firstCyc = lastIssue;
    issue(18'h01005);
    issue(18'h0100A); pairCyc = lastIssue;
    idle(2);
    issue(18'h0103F);
    idle(2);
    check("R3 no write while one offset pending", 32'(capN - s), 2);
    armDown();
    check("R8 row count after flush", 32'(capN - s), 3);
    check("R5 first row is full", 32'(capData[s]), 32'(mkFull(18'h01000)));
    check("R11 full row latency", 32'(capCyc[s]), 32'(firstCyc));
    check("R6 two-offset row", 32'(capData[s+1]), 32'(mkTwo(6'h05, 6'h0A)));
    check("R6 pair written on second strobe", 32'(capCyc[s+1]), 32'(pairCyc));
    check("R8 flushed one-offset row", 32'(capData[s+2]), 32'(mkOne(6'h3F)));
    check("R9 addresses", 32'({capAddr[s], capAddr[s+1], capAddr[s+2]}), 32'({6'd0, 6'd1, 6'd2}));
    check("R9 rowCount", 32'(rowCount), 3);
  endtask

  task automatic tOrderAcrossRegions();
    int s = capN;
    armIn = 1'b1;
    idle(1);
    issue(18'h20010);
    issue(18'h20011);
    issue(18'h20050);
    issue(18'h20052);
    issue(18'h3FFC0);
    armDown();
    check("R7 row count", 32'(capN - s), 5);
    check("R10 rearm restarts at 0", 32'(capAddr[s]), 0);
    check("R4 row0", 32'(capData[s]), 32'(mkFull(18'h20010)));
    check("R7 pending first", 32'(capData[s+1]), 32'(mkOne(6'h11)));
    check("R4 full after region change", 32'(capData[s+2]), 32'(mkFull(18'h20050)));
    check("R7 full follows next edge", 32'(capCyc[s+2]), 32'(capCyc[s+1] + 1));
    check("R7 offset after held PC", 32'(capData[s+3]), 32'(mkOne(6'h12)));
    check("R8 held PC flushed", 32'(capData[s+4]), 32'(mkFull(18'h3FFC0)));
  endtask

  task automatic tDeferredChain();
    int s = capN;
    armIn = 1'b1;
    issue(18'h01000);
    issue(18'h01001);
    issue(18'h02000);
    issue(18'h03000);
    armDown();
    check("R7 chain row count", 32'(capN - s), 4);
    check("R7 chain row1", 32'(capData[s+1]), 32'(mkOne(6'h01)));
    check("R7 chain row2", 32'(capData[s+2]), 32'(mkFull(18'h02000)));
    check("R4 chain row3", 32'(capData[s+3]), 32'(mkFull(18'h03000)));
    check("R7 chain consecutive", 32'(capCyc[s+3]), 32'(capCyc[s+2] + 1));
  endtask

  task automatic tIgnoredWhenDisarmed();
    int s = capN;
    logic [5:0] c0 = rowCount;
    issue(18'h00100);
    issue(18'h00A00);
    issue(18'h00A01);
    idle(3);
    check("R1 no rows while disarmed", 32'(capN - s), 0);
    check("R1 count unchanged", 32'(rowCount), 32'(c0));
    armIn = 1'b1;
    issue(18'h00155);
    armDown();
    check("R1 accepted when armed", 32'(capData[s]), 32'(mkFull(18'h00155)));
    check("R2 info field full", 32'(capData[s][19:18]), 2'b11);
  endtask

  task automatic tWrap();
    int s = capN;
    armIn = 1'b1;
    for (int i = 0; i < 66; i++) begin
      issue(18'(i << 6));
      if (i == 62) check("R10 no overflow before last address", 32'(overflowFlag), 0);
    end
    armDown();
    check("R9 wrap row count", 32'(capN - s), 66);
    check("R9 last address", 32'(capAddr[s+63]), 63);
    check("R9 wrapped address", 32'(capAddr[s+64]), 0);
    check("R9 rowCount after wrap", 32'(rowCount), 2);
    check("R10 overflow set", 32'(overflowFlag), 1);
    check("R4 row 65 data", 32'(capData[s+65]), 32'(mkFull(18'(65 << 6))));
    armIn = 1'b1;
    idle(1);
    check("R10 rearm clears count", 32'(rowCount), 0);
    check("R10 rearm clears overflow", 32'(overflowFlag), 0);
    armDown();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPackInRegion();
    tOrderAcrossRegions();
    tDeferredChain();
    tIgnoredWhenDisarmed();
    tWrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule